// File: doc/BRIEF.md
# Priority Interrupt Arbitration Unit

This block sits between the interrupt request pins of a processor and its microcode sequencer. It receives seven asynchronous request lines. Four are general device requests, and each of them needs an external vector read on the bus. The other three have fixed meanings: an interval timer, a power-fail warning and a halt request. The vectors for these three are produced on chip.

Every line passes through a two-flop synchronizer. A fixed-priority selector then picks the most urgent pending line and compares its level with the processor's current interrupt priority level.

At the start of each microcycle, marked by a one-cycle strobe, the unit registers a decision for the sequencer. The decision carries a take flag, the level, a flag that says whether a vector read is needed, and a 3-bit source code. Between strobes the decision holds its value, so the sequencer can sample it at any point in the microcycle.

Top module: `intarb_top`

## Requirements
- R1: While reset (rst_n low) is asserted, and on the first clock after it, irq_take, irq_lvl, irq_vec_rd and irq_src are all zero.
- R2: Every request line is synchronized by two flops. A request that is present before clock edge e can affect only the decision registered at edge e+2 or later. It becomes visible on the outputs after edge e+2 (the third edge, counting edge e).
- R3: Each source has a fixed level and a source code:
  - device lines 0..3 (dev_irq bit 0..3): levels 20..23, codes 0..3
  - interval timer: level 22, code 4
  - power fail: level 30, code 5
  - halt: level 31, code 7

  The pending source with the highest level wins. When the timer and device line 2 are both pending at level 22, the timer wins. Code 6 is never produced.
- R4: A winner other than halt is taken only if its level is strictly greater than cur_ipl, compared as 5-bit unsigned values and sampled at the strobe edge.
- R5: Halt cannot be masked. A synchronized halt request produces a take with code 7 and level 31, whatever cur_ipl is.
- R6: irq_vec_rd is 1 for a taken device line (codes 0..3) and 0 for a taken timer, power-fail or halt request.
- R7: The decision registers update only at clock edges where ucyc_stb is 1. At any other edge all four decision outputs keep their value.
- R8: Whenever irq_take is 0, irq_lvl, irq_src and irq_vec_rd are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_irq | input | 4 | Asynchronous device request lines 0..3 |
| tmr_irq | input | 1 | Asynchronous interval timer request |
| pwr_irq | input | 1 | Asynchronous power-fail request |
| hlt_irq | input | 1 | Asynchronous halt request |
| ucyc_stb | input | 1 | Microcycle start strobe; a decision is registered on this edge |
| cur_ipl | input | 5 | Current processor interrupt priority level |
| irq_take | output | 1 | Take-interrupt decision |
| irq_lvl | output | 5 | Level of the taken request |
| irq_vec_rd | output | 1 | Taken request needs an external vector read |
| irq_src | output | 3 | Source code of the taken request |

## Verification
Directed patterns come first:
- A single device line against a low priority level shows the synchronizer latency, edge by edge.
- A halt against the maximum priority level separates non-maskable from maskable handling.
- Changes to requests while the strobe is low show whether the decision is held.

Random request patterns and priority levels, with an irregular strobe, then tell the level ordering apart from the tie between timer and device line 2. They also separate the strict comparison from an inclusive one, since cur_ipl often equals the winner's level.

A behavioural reference that delays the requests by two edges checks every field on every cycle.

// File: rtl/intarb_pkg.sv
package intarb_pkg;

    localparam int IPL_W    = 5;
    localparam int NUM_DEV  = 4;
    localparam int NSRC     = NUM_DEV + 3;
    localparam int CODE_W   = 3;

    // request vector bit positions
    localparam int TMR_IDX  = NUM_DEV;
    localparam int PWR_IDX  = NUM_DEV + 1;
    localparam int HLT_IDX  = NUM_DEV + 2;

    // fixed levels
    localparam int LVL_DEV_BASE = 20;
    localparam int LVL_TMR      = 22;
    localparam int LVL_PWR      = 30;
    localparam int LVL_HLT      = 31;

    localparam logic [CODE_W-1:0] CODE_TMR = 3'd4;
    localparam logic [CODE_W-1:0] CODE_PWR = 3'd5;
    localparam logic [CODE_W-1:0] CODE_HLT = 3'd7;

    typedef logic [IPL_W-1:0] ipl_t;

    typedef struct packed {
        logic                take;
        ipl_t                lvl;
        logic                vec_rd;
        logic [CODE_W-1:0]   src;
    } dec_t;

    function automatic ipl_t src_level(input int idx);
        if (idx < NUM_DEV)       return IPL_W'(LVL_DEV_BASE + idx);
        else if (idx == TMR_IDX) return IPL_W'(LVL_TMR);
        else if (idx == PWR_IDX) return IPL_W'(LVL_PWR);
        else                     return IPL_W'(LVL_HLT);
    endfunction

    function automatic logic [CODE_W-1:0] src_code(input int idx);
        if (idx < NUM_DEV)       return CODE_W'(idx);
        else if (idx == TMR_IDX) return CODE_TMR;
        else if (idx == PWR_IDX) return CODE_PWR;
        else                     return CODE_HLT;
    endfunction

endpackage

// File: rtl/intarb_sync.sv
module intarb_sync #(
    parameter int W      = 7,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= '0;
                else        stg_q[g] <= stg_d[g];
            end
        end
    endgenerate

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/intarb_pick.sv
module intarb_pick
    import intarb_pkg::*;
(
    input  logic [NSRC-1:0]   req,
    output logic [NSRC-1:0]   grant,
    output logic              any,
    output ipl_t              lvl,
    output logic [CODE_W-1:0] code,
    output logic              vec_rd
);

    int   widx;
    ipl_t best;

    // later index wins a tie: timer (index 4) beats device line 2
    always_comb begin
        any  = 1'b0;
        best = '0;
        widx = 0;
        for (int i = 0; i < NSRC; i++) begin
            if (req[i] && (!any || src_level(i) >= best)) begin
                any  = 1'b1;
                best = src_level(i);
                widx = i;
            end
        end
        grant  = any ? (NSRC'(1) << widx) : '0;
        lvl    = any ? best : '0;
        code   = any ? src_code(widx) : '0;
        vec_rd = any && (widx < NUM_DEV);
    end

endmodule

// File: rtl/intarb_top.sv
module intarb_top
    import intarb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_DEV-1:0]  dev_irq,
    input  logic                tmr_irq,
    input  logic                pwr_irq,
    input  logic                hlt_irq,
    input  logic                ucyc_stb,
    input  logic [IPL_W-1:0]    cur_ipl,
    output logic                irq_take,
    output logic [IPL_W-1:0]    irq_lvl,
    output logic                irq_vec_rd,
    output logic [CODE_W-1:0]   irq_src
);

    logic [NSRC-1:0]   raw_req;
    logic [NSRC-1:0]   sync_req;
    logic [NSRC-1:0]   grant;
    logic              win_any;
    ipl_t              win_lvl;
    logic [CODE_W-1:0] win_code;
    logic              win_vec;
    dec_t              dec_d, dec_q;

    assign raw_req = {hlt_irq, pwr_irq, tmr_irq, dev_irq};

    intarb_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_req),
        .dout  (sync_req)
    );

    intarb_pick u_pick (
        .req    (sync_req),
        .grant  (grant),
        .any    (win_any),
        .lvl    (win_lvl),
        .code   (win_code),
        .vec_rd (win_vec)
    );

    always_comb begin
        dec_d = dec_q;
        if (ucyc_stb) begin
            dec_d = '0;
            if (win_any && (grant[HLT_IDX] || win_lvl > cur_ipl)) begin
                dec_d.take   = 1'b1;
                dec_d.lvl    = win_lvl;
                dec_d.vec_rd = win_vec;
                dec_d.src    = win_code;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign irq_take   = dec_q.take;
    assign irq_lvl    = dec_q.lvl;
    assign irq_vec_rd = dec_q.vec_rd;
    assign irq_src    = dec_q.src;

    // R7
    hold_between_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ucyc_stb |=> $stable(irq_take) && $stable(irq_lvl) && $stable(irq_src) && $stable(irq_vec_rd));

    // R4
    above_ipl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ucyc_stb |=> (!irq_take || irq_src == CODE_HLT || irq_lvl > $past(cur_ipl)));

    // R5
    halt_nonmask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ucyc_stb && sync_req[HLT_IDX]) |=> (irq_take && irq_src == CODE_HLT));

    // R6
    vec_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> (irq_vec_rd == (irq_src < CODE_W'(NUM_DEV))));

    // R8
    idle_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_take |-> (irq_lvl == '0 && irq_src == '0 && !irq_vec_rd));

endmodule

// File: tb/intarb_top_bench.sv
module intarb_top_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] dev_irq = '0;
    logic       tmr_irq = 1'b0, pwr_irq = 1'b0, hlt_irq = 1'b0;
    logic       ucyc_stb = 1'b0;
    logic [4:0] cur_ipl = '0;
    logic       irq_take, irq_vec_rd;
    logic [4:0] irq_lvl;
    logic [2:0] irq_src;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    intarb_top u_intarb_top (
        .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq), .tmr_irq(tmr_irq),
        .pwr_irq(pwr_irq), .hlt_irq(hlt_irq), .ucyc_stb(ucyc_stb),
        .cur_ipl(cur_ipl), .irq_take(irq_take), .irq_lvl(irq_lvl),
        .irq_vec_rd(irq_vec_rd), .irq_src(irq_src)
    );

    // reference model: priority list and level table
    int order[$] = '{6, 5, 3, 4, 2, 1, 0};
    int lvtab[7] = '{20, 21, 22, 23, 22, 30, 31};
    int cdtab[7] = '{0, 1, 2, 3, 4, 5, 7};

    logic [6:0] h1 = '0, h2 = '0;
    int  e_take = 0, e_lvl = 0, e_vec = 0, e_src = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            h1 = '0; h2 = '0;
            e_take = 0; e_lvl = 0; e_vec = 0; e_src = 0;
        end else begin
            if (ucyc_stb) begin
                e_take = 0; e_lvl = 0; e_vec = 0; e_src = 0;
                foreach (order[k]) begin
                    int s;
                    s = order[k];
                    if (h2[s]) begin
                        if (s == 6 || lvtab[s] > int'(cur_ipl)) begin
                            e_take = 1; e_lvl = lvtab[s];
                            e_src = cdtab[s]; e_vec = (s < 4) ? 1 : 0;
                        end
                        break;
                    end
                end
            end
            h2 = h1;
            h1 = {hlt_irq, pwr_irq, tmr_irq, dev_irq};
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cmp_model();
        check(int'(irq_take) == e_take, "R4 take", irq_take, e_take);
        check(int'(irq_src) == e_src, "R3 source", irq_src, e_src);
        check(int'(irq_lvl) == e_lvl, "R3 level", irq_lvl, e_lvl);
        check(int'(irq_vec_rd) == e_vec, "R6 vector flag", irq_vec_rd, e_vec);
        if (!irq_take)
            check(irq_lvl == 0 && irq_src == 0 && !irq_vec_rd, "R8 idle fields",
                  {irq_lvl, irq_src, irq_vec_rd}, 0);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        cmp_model();
    endtask

    task automatic clear_in();
        dev_irq = '0; tmr_irq = 0; pwr_irq = 0; hlt_irq = 0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!irq_take && irq_lvl == 0 && irq_src == 0 && !irq_vec_rd, "R1 reset",
              {irq_take, irq_lvl, irq_src, irq_vec_rd}, 0);
        rst_n = 1'b1;
        ucyc_stb = 1;
        step();
        check(!irq_take, "R1 first cycle", irq_take, 0);

        // R2 synchronizer latency: dev line 0 at ipl 0
        cur_ipl = 0; dev_irq = 4'b0001;
        step(); check(!irq_take, "R2 edge1", irq_take, 0);
        step(); check(!irq_take, "R2 edge2", irq_take, 0);
        step(); check(irq_take && irq_src == 0 && irq_lvl == 20, "R2 edge3", irq_take, 1);
        clear_in(); repeat (3) step();

        // R5 halt at maximum ipl
        cur_ipl = 31; hlt_irq = 1; dev_irq = 4'b1111;
        repeat (3) step();
        check(irq_take && irq_src == 7 && irq_lvl == 31 && !irq_vec_rd, "R5 halt",
              {irq_take, irq_src}, 15);
        hlt_irq = 0; repeat (3) step();
        check(!irq_take, "R4 masked at ipl 31", irq_take, 0);

        // R3 tie at level 22: timer over device 2
        clear_in(); cur_ipl = 0; tmr_irq = 1; dev_irq = 4'b0100;
        repeat (3) step();
        check(irq_src == 4 && irq_lvl == 22, "R3 tie timer", irq_src, 4);
        // R4 strict compare: ipl equal to level
        cur_ipl = 22; step();
        check(!irq_take, "R4 equal level", irq_take, 0);

        // R7 hold while strobe low
        cur_ipl = 0; step();
        ucyc_stb = 0; clear_in(); cur_ipl = 31;
        repeat (4) step();
        check(irq_take && irq_src == 4, "R7 hold", irq_src, 4);
        ucyc_stb = 1; repeat (3) step();
        check(!irq_take, "R7 update", irq_take, 0);

        // random patterns
        for (int c = 0; c < 4000; c++) begin
            dev_irq  = 4'($urandom) & 4'($urandom);
            tmr_irq  = ($urandom % 4) == 0;
            pwr_irq  = ($urandom % 6) == 0;
            hlt_irq  = ($urandom % 10) == 0;
            cur_ipl  = ($urandom % 3 == 0) ? 5'(18 + $urandom % 14) : 5'($urandom);
            ucyc_stb = ($urandom % 4) != 0;
            step();
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule